// File: doc/BRIEF.md
# Mailbox Receive-Pending Flag Register

This block holds one pending flag for each of the 32 message mailboxes of a CAN-style controller. A flag goes high when a complete data frame has been stored in its mailbox. A flag can set only if the mailbox is configured to receive data frames. Remote frames never set a flag. Software sees the flags as two 16-bit registers and clears any flag by writing 1 to its bit.

Each mailbox also has an interrupt mask bit. When an unmasked flag sets, the block raises a summary "data frame received" flag. That summary flag has its own write-1-to-clear bit. A global receive-interrupt mask then gates the summary flag onto the interrupt output.

Frame reception, mailbox storage and the rest of the register map sit outside this block. Their effect arrives here only as a one-cycle store strobe.

Top module: `mbx_rx_pend`

## Requirements
- R1: Register addresses. Address 0 reads mailboxes 15..0, with mailbox i at bit i. Address 1 reads mailboxes 31..16, with mailbox i at bit i-16. Address 2 reads the summary flag in bit 0 and zeros in bits 15..1.
- R2: After reset, every pending flag, the summary flag and `irq_o` are 0.
- R3: A strobe on `store_vld_i` with `store_data_i`=1 for a mailbox configured with code 3'b010 (receive data frame) sets that mailbox's flag on the next clock edge.
- R4: A store strobe for a mailbox whose 3-bit configuration code (bits [3i+2:3i] of `mbx_cfg_i`) is not 3'b010 changes no flag.
- R5: A store strobe with `store_data_i`=0 (remote frame) changes no flag, even on a mailbox configured with 3'b010.
- R6: A write of 1 to a bit at address 0 or 1 clears that flag. A write of 0 leaves the flag unchanged. No write can set a flag.
- R7: The summary flag sets when a flag sets for a mailbox whose `mbx_imask_i` bit is 0. A flag setting on a mailbox whose mask bit is 1 does not set the summary flag. Writing 1 to bit 0 at address 2 clears the summary flag.
- R8: `irq_o` is high exactly while the summary flag is 1 and `rx_imask_i` is 0.
- R9: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set. This holds for a mailbox flag and for the summary flag.
- R10: Reads have no side effect. Reading the same address twice returns the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| store_vld_i | input | 1 | One-cycle strobe: a frame has been stored completely in a mailbox |
| store_idx_i | input | 5 | Mailbox number of the stored frame |
| store_data_i | input | 1 | 1 = data frame, 0 = remote frame |
| mbx_cfg_i | input | 96 | 3-bit configuration code per mailbox; mailbox i at [3i+2:3i] |
| mbx_imask_i | input | 32 | Per-mailbox interrupt mask; 1 = masked |
| rx_imask_i | input | 1 | Global mask for the receive interrupt; 1 = masked |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register select: 0 low flags, 1 high flags, 2 summary |
| reg_wdata_i | input | 16 | Write data; 1 bits clear flags |
| reg_rdata_o | output | 16 | Read data for the selected register |
| rx_flag_o | output | 1 | Summary data-frame-received flag |
| irq_o | output | 1 | Receive interrupt output |

## Verification
The assertions check these rules on every cycle:
- A flag rises only after a decoded set.
- A clear without a set drops the flag, and an idle cycle holds it.
- A remote frame or a non-receive configuration never produces a set.
- The summary flag follows unmasked sets.

Some behaviours only the bench scenarios can show:
- The register layout across the two words.
- The two-level interrupt gating, including a masked mailbox next to an unmasked one.
- The same-cycle set-versus-clear collisions as seen at the read port.
- The reads that leave the state unchanged.

// File: rtl/mbx_rxp_pkg.sv
package mbx_rxp_pkg;
  localparam int unsigned CFG_W = 3;
  localparam logic [CFG_W-1:0] CFG_RX_DATA = 3'b010;
endpackage

// File: rtl/rxp_set_decode.sv
module rxp_set_decode
  import mbx_rxp_pkg::*;
#(
  parameter int unsigned NUM_MBX = 32,
  parameter int unsigned IDX_W   = $clog2(NUM_MBX)
) (
  input  logic                     vld_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic                     is_data_i,
  input  logic [NUM_MBX*CFG_W-1:0] cfg_i,
  output logic [NUM_MBX-1:0]       set_o
);
  for (genvar i = 0; i < NUM_MBX; i++) begin : g_dec
    assign set_o[i] = vld_i && is_data_i && (idx_i == IDX_W'(i)) &&
                      (cfg_i[i*CFG_W +: CFG_W] == CFG_RX_DATA);
  end
endmodule

// File: rtl/rxp_flag_bank.sv
module rxp_flag_bank #(
  parameter int unsigned NUM_MBX = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_MBX-1:0] set_i,
  input  logic [NUM_MBX-1:0] clr_i,
  output logic [NUM_MBX-1:0] pend_o
);
  logic [NUM_MBX-1:0] pend_q;

  for (genvar i = 0; i < NUM_MBX; i++) begin : g_bit
    // set has priority over clear so no reception is lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q[i] <= 1'b0;
      else if (set_i[i]) pend_q[i] <= 1'b1;
      else if (clr_i[i]) pend_q[i] <= 1'b0;
    end

    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> pend_q[i]);
    a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !pend_q[i]);
    a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[i] && pend_q[i]) |=> pend_q[i]);
    a_r3_only_by_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_q[i] && !set_i[i]) |=> !pend_q[i]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/rxp_summary.sv
module rxp_summary #(
  parameter int unsigned NUM_MBX = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_MBX-1:0] set_i,
  input  logic [NUM_MBX-1:0] imask_i,
  input  logic               clr_i,
  input  logic               gmask_i,
  output logic               flag_o,
  output logic               irq_o
);
  logic flag_q;
  logic hit;

  assign hit = |(set_i & ~imask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && !gmask_i;

  a_r7_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & ~imask_i)) |=> flag_q);
  a_r7_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !(|(set_i & ~imask_i))) |=> !flag_q);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(|(set_i & ~imask_i))) |=> !flag_q);
endmodule

// File: rtl/mbx_rx_pend.sv
module mbx_rx_pend
  import mbx_rxp_pkg::*;
#(
  parameter int unsigned NUM_MBX = 32,
  parameter int unsigned REG_W   = 16,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned IDX_W   = $clog2(NUM_MBX)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     store_vld_i,
  input  logic [IDX_W-1:0]         store_idx_i,
  input  logic                     store_data_i,
  input  logic [NUM_MBX*CFG_W-1:0] mbx_cfg_i,
  input  logic [NUM_MBX-1:0]       mbx_imask_i,
  input  logic                     rx_imask_i,
  input  logic                     reg_we_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [REG_W-1:0]         reg_wdata_i,
  output logic [REG_W-1:0]         reg_rdata_o,
  output logic                     rx_flag_o,
  output logic                     irq_o
);
  localparam int unsigned NUM_WORDS = NUM_MBX / REG_W;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_WORDS);

  logic [NUM_MBX-1:0] set_vec;
  logic [NUM_MBX-1:0] clr_vec;
  logic [NUM_MBX-1:0] pend;
  logic               stat_clr;

  rxp_set_decode #(.NUM_MBX(NUM_MBX), .IDX_W(IDX_W)) u_dec (
    .vld_i    (store_vld_i),
    .idx_i    (store_idx_i),
    .is_data_i(store_data_i),
    .cfg_i    (mbx_cfg_i),
    .set_o    (set_vec)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign clr_vec[w*REG_W +: REG_W] =
      (reg_we_i && reg_addr_i == ADDR_W'(w)) ? reg_wdata_i : '0;
  end

  assign stat_clr = reg_we_i && (reg_addr_i == STAT_ADDR) && reg_wdata_i[0];

  rxp_flag_bank #(.NUM_MBX(NUM_MBX)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .pend_o(pend)
  );

  rxp_summary #(.NUM_MBX(NUM_MBX)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .imask_i(mbx_imask_i),
    .clr_i  (stat_clr),
    .gmask_i(rx_imask_i),
    .flag_o (rx_flag_o),
    .irq_o  (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (reg_addr_i == ADDR_W'(w)) reg_rdata_o = pend[w*REG_W +: REG_W];
    end
    if (reg_addr_i == STAT_ADDR) reg_rdata_o[0] = rx_flag_o;
  end

  a_r5_remote_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_vld_i && !store_data_i) |-> (set_vec == '0));
  a_r4_cfg_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_vld_i && mbx_cfg_i[store_idx_i*CFG_W +: CFG_W] != CFG_RX_DATA)
      |-> (set_vec == '0));
  a_r3_single_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_vec) && ((|set_vec) -> store_vld_i));
endmodule

// File: tb/test_mbx_rx_pend.sv
module test_mbx_rx_pend;
  typedef struct {
    int          kind;   // 0 rdata, 1 irq_o, 2 rx_flag_o
    logic [15:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        store_vld = 1'b0;
  logic [4:0]  store_idx = '0;
  logic        store_data = 1'b0;
  logic [95:0] mbx_cfg;
  logic [31:0] mbx_imask;
  logic        rx_imask = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        rx_flag;
  logic        irq;

  item_t q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  logic [31:0] m_pend = '0;
  logic        m_flag = 1'b0;

  always #4 clk = ~clk;

  mbx_rx_pend i_mbx_rx_pend (
    .clk_i(clk), .rst_ni(rst_n),
    .store_vld_i(store_vld), .store_idx_i(store_idx), .store_data_i(store_data),
    .mbx_cfg_i(mbx_cfg), .mbx_imask_i(mbx_imask), .rx_imask_i(rx_imask),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .rx_flag_o(rx_flag), .irq_o(irq)
  );

  // monitor: compares expected items after the edge that follows their push
  always @(posedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = reg_rdata;
        1:       act = {15'b0, irq};
        default: act = {15'b0, rx_flag};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  function automatic logic [2:0] cfg_of(input int i);
    return mbx_cfg[i*3 +: 3];
  endfunction

  // one bus/strobe cycle, then model update from the requirements
  task automatic cyc(input bit vld, input int idx, input bit dat,
                     input bit we, input logic [1:0] a, input logic [15:0] wd);
    logic [31:0] set, clr;
    bit sclr, shit;
    store_vld = vld; store_idx = 5'(idx); store_data = dat;
    reg_we = we; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    store_vld = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    set = '0; clr = '0;
    if (vld && dat && cfg_of(idx) == 3'b010) set[idx] = 1'b1;
    if (we && a == 2'd0) clr[15:0]  = wd;
    if (we && a == 2'd1) clr[31:16] = wd;
    sclr = we && a == 2'd2 && wd[0];
    shit = |(set & ~mbx_imask);
    m_pend = (m_pend & ~clr) | set;
    m_flag = shit ? 1'b1 : (sclr ? 1'b0 : m_flag);
  endtask

  task automatic chk_reg(input logic [1:0] a, input string req);
    logic [15:0] e;
    reg_addr = a;
    case (a)
      2'd0:    e = m_pend[15:0];
      2'd1:    e = m_pend[31:16];
      default: e = {15'b0, m_flag};
    endcase
    q.push_back('{0, e, req});
    @(negedge clk);
  endtask

  task automatic chk_irq(input string req);
    q.push_back('{1, {15'b0, m_flag && !rx_imask}, req});
    q.push_back('{2, {15'b0, m_flag}, req});
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mbx_cfg[i*3 +: 3] = 3'b010;
    mbx_cfg[5*3 +: 3]  = 3'b001;
    mbx_cfg[20*3 +: 3] = 3'b000;
    mbx_imask = 32'h0000_0008;  // mailbox 3 masked
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk_reg(2'd0, "R2"); chk_reg(2'd1, "R2"); chk_reg(2'd2, "R2"); chk_irq("R2");
    // R3 / R1 / R7 / R8: data frame on mailbox 0 and 17
    cyc(1, 0, 1, 0, 0, 0);
    chk_reg(2'd0, "R3"); chk_irq("R8");
    cyc(1, 17, 1, 0, 0, 0);
    chk_reg(2'd1, "R1"); chk_reg(2'd2, "R1");
    // R5: remote frame ignored
    cyc(1, 1, 0, 0, 0, 0);
    chk_reg(2'd0, "R5");
    // R4: non-receive configurations ignored
    cyc(1, 5, 1, 0, 0, 0);
    chk_reg(2'd0, "R4");
    cyc(1, 20, 1, 0, 0, 0);
    chk_reg(2'd1, "R4");
    // R6: write 0 no effect, write 1 clears
    cyc(0, 0, 0, 1, 2'd0, 16'h0000);
    chk_reg(2'd0, "R6");
    cyc(0, 0, 0, 1, 2'd0, 16'h0001);
    chk_reg(2'd0, "R6");
    cyc(0, 0, 0, 1, 2'd1, 16'h0002);
    chk_reg(2'd1, "R6");
    // R7: summary clear, then masked mailbox does not set it
    cyc(0, 0, 0, 1, 2'd2, 16'h0001);
    chk_reg(2'd2, "R7"); chk_irq("R7");
    cyc(1, 3, 1, 0, 0, 0);
    chk_reg(2'd0, "R7"); chk_reg(2'd2, "R7");
    // R8: global mask gates irq
    rx_imask = 1'b1;
    cyc(1, 31, 1, 0, 0, 0);
    chk_irq("R8"); chk_reg(2'd1, "R8");
    rx_imask = 1'b0;
    @(negedge clk);
    chk_irq("R8");
    // R9: set and clear on same bit/flag in one cycle
    cyc(1, 3, 1, 1, 2'd0, 16'h0008);
    chk_reg(2'd0, "R9");
    cyc(1, 4, 1, 1, 2'd2, 16'h0001);
    chk_reg(2'd2, "R9"); chk_reg(2'd0, "R9");
    // R10: repeated reads return the same value
    chk_reg(2'd1, "R10"); chk_reg(2'd1, "R10");
    chk_reg(2'd0, "R10"); chk_reg(2'd0, "R10");
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule